// File: doc/BRIEF.md
# Masked Alarm Match Interrupt Controller

This block watches the running time of a real-time clock and raises interrupts when it reaches one of two programmed alarm times. Every time the clock updates (signalled by a one-cycle update strobe), each alarm compares its seconds, minutes, hours and day-of-week settings against the live time. Any field can be marked "don't care" with its own mask bit. When an alarm matches, the block sets that alarm's request flag. The flag stays set until the register access logic reports that the access pointer has reached one of that alarm's registers.

Two active-low interrupt lines are driven from the flags. An enable bit per alarm gates each flag's effect on the lines. A routing bit chooses between two arrangements. In one, each alarm owns its own line. In the other, both alarms share line 0 and line 1 stays idle. The lines model open-drain outputs: a 0 means the line is pulled low and a 1 means it is released. The flags are also presented as a status byte.

Top module: `alarm_match_irq`

## Requirements
- R1: After reset both request flags are 0, the status byte is 8'h00 and both interrupt lines read 1 (released).
- R2: Each alarm setting byte holds the mask in bit 7 and the BCD compare value in bits 6:0. A field whose mask is 1 matches any live value. A field whose mask is 0 matches only when bits 6:0 equal the live field's bits 6:0.
- R3: An alarm's flag is set at the clock edge where the update strobe is 1 and all four of its fields match. A full match with the strobe at 0 sets nothing.
- R4: With all four masks set to 1 (byte pattern 8'h80 in every field), the flag sets on every update.
- R5: With no mask set, a flag whose day differs stays clear even when seconds, minutes and hours all match.
- R6: A set flag stays set across later updates that do not match, until it is cleared.
- R7: A per-alarm touch pulse clears that alarm's flag at the next edge. If a set and a clear of the same flag meet in one cycle, the flag ends up set.
- R8: With the routing bit at 1, line 0 is low exactly when flag 0 and enable 0 are both 1, and line 1 is low exactly when flag 1 and enable 1 are both 1.
- R9: With the routing bit at 0, line 0 is low when either alarm's flag is set together with its enable, and line 1 stays released.
- R10: An enable bit of 0 keeps its flag off the interrupt lines but does not stop the flag from being set or shown in the status byte.
- R11: The status byte carries flag 0 in bit 0 and flag 1 in bit 1. Bits 7:2 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_stb | input | 1 | One-cycle pulse at each time update |
| now_time | input | 32 | Live time; bytes are seconds [7:0], minutes [15:8], hours [23:16], day [31:24] |
| alm_set | input | 64 | Alarm settings; alarm a field f at bits [a*32+f*8 +: 8], same field order as now_time |
| ptr_touch | input | 2 | Bit a pulses when the access pointer reaches an alarm a register |
| route_sep | input | 1 | 1: each alarm has its own line; 0: both alarms share line 0 |
| irq_en | input | 2 | Per-alarm interrupt enable |
| status_byte | output | 8 | Request flags, bit 0 = alarm 0, bit 1 = alarm 1 |
| irq_n | output | 2 | Active-low interrupt lines, 1 = released |

## Verification
Several relations are checked by assertions on every cycle. A flag can rise only after a cycle with the update strobe. A touch without a strobe leaves the flag clear. A flag holds when there is neither a strobe nor a touch. A low interrupt line always has an enabled flag behind it, and line 1 is released whenever routing is merged. Only the bench scenarios can show the rest: which mask patterns and field values count as a match, that a set wins over a clear in the same cycle, and the exact value on each line under each routing and enable setting.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int unsigned N_ALARM  = 2;
    localparam int unsigned N_FIELD  = 4;
    localparam int unsigned FIELD_W  = 8;
    localparam int unsigned MASK_BIT = FIELD_W - 1;
    localparam int unsigned SET_W    = N_FIELD * FIELD_W;

    typedef struct packed {
        logic [N_ALARM-1:0] flag;
    } alarm_state_t;
endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
    import alarm_irq_pkg::*;
(
    input  logic [SET_W-1:0] now_time,
    input  logic [SET_W-1:0] alm_cfg,
    output logic             hit
);
    logic [N_FIELD-1:0] fld_ok;

    for (genvar f = 0; f < N_FIELD; f++) begin : g_fld
        logic [FIELD_W-1:0] cfg_b;
        logic [FIELD_W-1:0] now_b;
        assign cfg_b = alm_cfg[f*FIELD_W +: FIELD_W];
        assign now_b = now_time[f*FIELD_W +: FIELD_W];
        assign fld_ok[f] = cfg_b[MASK_BIT] ||
                           (cfg_b[MASK_BIT-1:0] == now_b[MASK_BIT-1:0]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/alarm_irq_route.sv
module alarm_irq_route
    import alarm_irq_pkg::*;
(
    input  logic [N_ALARM-1:0] flag,
    input  logic [N_ALARM-1:0] irq_en,
    input  logic               route_sep,
    output logic [N_ALARM-1:0] irq_n
);
    logic [N_ALARM-1:0] req;
    assign req = flag & irq_en;

    always_comb begin
        irq_n = '1;
        if (route_sep) begin
            irq_n = ~req;
        end else begin
            irq_n[0] = ~(|req);
        end
    end
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
    import alarm_irq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd_stb,
    input  logic [SET_W-1:0]         now_time,
    input  logic [N_ALARM*SET_W-1:0] alm_set,
    input  logic [N_ALARM-1:0]       ptr_touch,
    input  logic                     route_sep,
    input  logic [N_ALARM-1:0]       irq_en,
    output logic [7:0]               status_byte,
    output logic [N_ALARM-1:0]       irq_n
);
    alarm_state_t st_d, st_q;
    logic [N_ALARM-1:0] hit;

    for (genvar a = 0; a < N_ALARM; a++) begin : g_alm
        alarm_field_match u_match (
            .now_time (now_time),
            .alm_cfg  (alm_set[a*SET_W +: SET_W]),
            .hit      (hit[a])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int a = 0; a < N_ALARM; a++) begin
            if (ptr_touch[a]) st_d.flag[a] = 1'b0;
            if (upd_stb && hit[a]) st_d.flag[a] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_byte = {{(8-N_ALARM){1'b0}}, st_q.flag};

    alarm_irq_route u_route (
        .flag      (st_q.flag),
        .irq_en    (irq_en),
        .route_sep (route_sep),
        .irq_n     (irq_n)
    );

    // R3
    flag0_rise_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[0]) |-> $past(upd_stb));
    // R3
    flag1_rise_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_byte[1]) |-> $past(upd_stb));
    // R7
    touch0_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_touch[0] && !upd_stb) |=> !status_byte[0]);
    // R7
    touch1_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_touch[1] && !upd_stb) |=> !status_byte[1]);
    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_stb && ptr_touch == '0) |=> $stable(status_byte));
    // R9
    merged_line1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sep |-> irq_n[1]);
    // R10
    low_line_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n[0] |-> ((status_byte[0] && irq_en[0]) || (status_byte[1] && irq_en[1])));
endmodule

// File: tb/alarm_match_irq_tb.sv
module alarm_match_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_stb = 1'b0;
    logic [31:0] now_time = '0;
    logic [63:0] alm_set = '0;
    logic [1:0]  ptr_touch = '0;
    logic        route_sep = 1'b1;
    logic [1:0]  irq_en = '0;
    logic [7:0]  status_byte;
    logic [1:0]  irq_n;

    int total = 0;
    int bad = 0;
    bit m_flag [2];

    always #10 clk = ~clk;

    alarm_match_irq u_dut (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .now_time(now_time),
        .alm_set(alm_set), .ptr_touch(ptr_touch), .route_sep(route_sep),
        .irq_en(irq_en), .status_byte(status_byte), .irq_n(irq_n)
    );

    function automatic bit ref_hit(int a);
        for (int f = 0; f < 4; f++) begin
            int cfg = alm_set[a*32 + f*8 +: 8];
            int nv  = now_time[f*8 +: 8];
            if (cfg < 128 && cfg != (nv % 128)) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic compare(string req);
        logic [7:0] exp_st;
        logic [1:0] exp_irq;
        bit r0, r1;
        exp_st = 8'(m_flag[0]) + 8'(m_flag[1]) * 8'd2;
        r0 = m_flag[0] && irq_en[0];
        r1 = m_flag[1] && irq_en[1];
        if (route_sep) exp_irq = {~r1, ~r0};
        else           exp_irq = {1'b1, ~(r0 | r1)};
        total++;
        if (status_byte !== exp_st) begin
            bad++;
            $display("FAIL %s status actual=%h expected=%h", req, status_byte, exp_st);
        end
        total++;
        if (irq_n !== exp_irq) begin
            bad++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp_irq);
        end
    endtask

    task automatic step(bit stb, logic [1:0] touch, string req);
        upd_stb = stb;
        ptr_touch = touch;
        @(posedge clk);
        for (int a = 0; a < 2; a++) begin
            if (touch[a]) m_flag[a] = 1'b0;
            if (stb && ref_hit(a)) m_flag[a] = 1'b1;
        end
        @(negedge clk);
        upd_stb = 1'b0;
        ptr_touch = '0;
        compare(req);
    endtask

    task automatic set_alarm(int a, logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
        alm_set[a*32 +: 32] = {d, h, m, s};
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_flag[0] = 1'b0;
        m_flag[1] = 1'b0;
        repeat (2) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R3: full match without strobe, then with
        irq_en = 2'b11;
        set_alarm(0, 8'h45, 8'h30, 8'h12, 8'h03);
        set_alarm(1, 8'h00, 8'h00, 8'h00, 8'h07);
        now_time = {8'h03, 8'h12, 8'h30, 8'h45};
        step(0, 2'b00, "R3");
        step(1, 2'b00, "R3");
        compare("R11");

        // R10: enable off hides line but keeps flag
        irq_en = 2'b10;
        @(negedge clk);
        compare("R10");
        irq_en = 2'b11;

        // R6: later non-matching updates keep flag
        now_time = {8'h03, 8'h12, 8'h30, 8'h46};
        step(1, 2'b00, "R6");
        step(1, 2'b00, "R6");

        // R7: touch clears, set wins same cycle
        step(0, 2'b01, "R7");
        now_time = {8'h03, 8'h12, 8'h30, 8'h45};
        step(1, 2'b01, "R7");
        step(0, 2'b01, "R7");

        // R5: day differs with no mask
        set_alarm(1, 8'h10, 8'h20, 8'h08, 8'h04);
        now_time = {8'h05, 8'h08, 8'h20, 8'h10};
        step(1, 2'b00, "R5");
        now_time = {8'h04, 8'h08, 8'h20, 8'h10};
        step(1, 2'b00, "R5");
        step(0, 2'b10, "R7");

        // R2: seconds-only pattern, masked fields carry garbage
        set_alarm(1, 8'h33, 8'hD9, 8'hA2, 8'hFF);
        now_time = {8'h06, 8'h17, 8'h58, 8'h32};
        step(1, 2'b00, "R2");
        now_time = {8'h06, 8'h17, 8'h58, 8'h33};
        step(1, 2'b00, "R2");
        now_time = {8'h06, 8'h17, 8'h58, 8'hB3};
        step(0, 2'b10, "R2");
        step(1, 2'b00, "R2");

        // R8: separate routing
        route_sep = 1'b1;
        @(negedge clk);
        compare("R8");
        irq_en = 2'b01;
        @(negedge clk);
        compare("R8");
        irq_en = 2'b11;

        // R9: merged routing
        route_sep = 1'b0;
        @(negedge clk);
        compare("R9");
        step(0, 2'b01, "R9");
        irq_en = 2'b01;
        @(negedge clk);
        compare("R9");
        irq_en = 2'b11;
        step(0, 2'b10, "R9");
        route_sep = 1'b1;

        // R4: every-second pattern
        set_alarm(0, 8'h80, 8'h80, 8'h80, 8'h80);
        for (int i = 0; i < 5; i++) begin
            now_time = {8'h01, 8'h00, 8'h00, 8'(i)};
            step(0, 2'b01, "R4");
            step(1, 2'b00, "R4");
        end

        // R1: reset mid-run
        rst_n = 1'b0;
        m_flag[0] = 1'b0;
        m_flag[1] = 1'b0;
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule